// File: doc/BRIEF.md
# Supply Voltage Monitor Interrupt Logic

This block is the digital back end of a supply-voltage monitor that has one comparator for an under-voltage threshold and one for an over-voltage threshold. Each raw comparator output is brought into the bus clock domain by a two-flop synchroniser. It then passes a stable-sample filter, and only a level that holds for FILT_N consecutive clocks is accepted. The filtered level is gated by the sensing enables to form the low and high condition bits.

Each condition bit drives a sticky interrupt flag. The flag sets whenever the condition bit changes, in either direction, and the host clears it by writing 1 to it. The two flags are masked by their local enables and merged into one interrupt line. That line is held inactive while the stop input is high. The flags themselves are not affected by stop. A small register port exposes a control word and a status word. A two-bit low-threshold code is driven out to the analog side.

Sensing off forces both condition bits to 0. Switching sensing off while a condition is active is therefore a change of state, and it raises one more interrupt. Software that does not want that interrupt clears the local enable first.

Top module: `supply_mon_irq`

## Requirements
- R1: After reset, the control word, the status word, thr_sel_o and irq_o are all 0.
- R2: Address 0 holds the control word, which reads back as written: bit 0 is sense enable A, bit 1 is sense enable B, bits 3:2 are the low-threshold code, bit 4 is the low interrupt enable and bit 5 is the high interrupt enable. Address 1 is the status word: bit 0 is the low condition, bit 1 is the high condition, bit 2 is the low flag and bit 3 is the high flag.
- R3: thr_sel_o always equals control bits 3:2, and all four codes 0 to 3 are possible.
- R4: A raw comparator change reaches its condition bit on the (FILT_N+2)th rising edge after the input changes, counting the first edge that samples it as edge 1. A deviation lasting FILT_N-1 clocks or less leaves the condition bit unchanged.
- R5: Both condition bits are 0 while sense enables A and B are both 0. Either enable on its own is enough for a condition to become 1.
- R6: A flag sets on the clock after its condition bit changes, on a 0-to-1 change and on a 1-to-0 change alike.
- R7: Clearing both sense enables while a condition is 1 sets that condition's flag.
- R8: Writing 1 to a flag bit at address 1 clears that flag, and writing 0 leaves it unchanged. If a set event and a clearing write occur in the same cycle, the flag ends up 1.
- R9: irq_o is 1 exactly when stop_i is 0 and at least one flag is 1 with its interrupt enable set.
- R10: While stop_i is 1, irq_o is 0. Raising or lowering stop_i does not change either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Stop mode indication; masks irq_o |
| cmp_low_i | input | 1 | Raw under-voltage comparator output |
| cmp_high_i | input | 1 | Raw over-voltage comparator output |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 is control, 1 is status |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| thr_sel_o | output | 2 | Low-threshold code to the analog side |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench drives comparator pulses one clock shorter than the filter window and then a held change, and samples the clock just before and the clock just after the expected update. A design with an off-by-one filter count, or with one synchroniser stage too few or too many, is caught there. The condition is driven low and then high, so a flag that fires only on rising changes misses the falling one. Sensing is switched off with a condition active, which catches a design that samples the raw comparator rather than the gated condition. A clearing write is placed in the same cycle as a set event, which exposes a design where the clear wins. Stop is toggled with a flag set and then with no flag set, to show that irq_o alone is masked and that a design which clears or sets flags on stop is wrong.

// File: rtl/supply_mon_pkg.sv
package supply_mon_pkg;
  localparam int unsigned NSRC     = 2;   // index 0 low, 1 high
  localparam int unsigned ADDR_W   = 1;
  localparam int unsigned THR_W    = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 1'b1;
  localparam int unsigned CTRL_SENSE_LSB = 0;
  localparam int unsigned CTRL_THR_LSB   = 2;
  localparam int unsigned CTRL_IE_LSB    = 4;
  localparam int unsigned STAT_COND_LSB  = 0;
  localparam int unsigned STAT_FLAG_LSB  = 2;
  localparam int unsigned CTRL_USED      = CTRL_IE_LSB + NSRC;
endpackage

// File: rtl/sm_filter.sv
module sm_filter #(
  parameter int unsigned FILT_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CNT_W = (FILT_N > 2) ? $clog2(FILT_N) : 1;

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_N - 1)) begin
        cnt_q  <= '0;
        filt_o <= s2_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sm_flag.sv
module sm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic clr_i,
  output logic flag_o
);
  logic cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      cond_q <= cond_i;
      // a change of state outranks a clearing write
      flag_o <= (cond_i ^ cond_q) | (flag_o & ~clr_i);
    end
  end
endmodule

// File: rtl/supply_mon_irq.sv
module supply_mon_irq
  import supply_mon_pkg::*;
#(
  parameter int unsigned FILT_N = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              cmp_low_i,
  input  logic              cmp_high_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [THR_W-1:0]  thr_sel_o,
  output logic              irq_o
);
  logic [1:0]      sense_q;
  logic [THR_W-1:0] thr_q;
  logic [NSRC-1:0] ie_q;
  logic [NSRC-1:0] raw, filt, cond, flag, clr;
  logic            sense_any;
  logic            wr_ctrl, wr_stat;
  logic            unused_wdata;

  assign wr_ctrl      = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat      = wr_i && (addr_i == ADDR_STAT);
  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_USED];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      thr_q   <= '0;
      ie_q    <= '0;
    end else if (wr_ctrl) begin
      sense_q <= wdata_i[CTRL_SENSE_LSB +: 2];
      thr_q   <= wdata_i[CTRL_THR_LSB +: THR_W];
      ie_q    <= wdata_i[CTRL_IE_LSB +: NSRC];
    end
  end

  assign sense_any = |sense_q;
  assign raw       = {cmp_high_i, cmp_low_i};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    sm_filter #(.FILT_N(FILT_N)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[i]),
      .filt_o(filt[i])
    );
    assign cond[i] = filt[i] & sense_any;
    assign clr[i]  = wr_stat & wdata_i[STAT_FLAG_LSB + i];
    sm_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cond_i(cond[i]),
      .clr_i (clr[i]),
      .flag_o(flag[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[CTRL_SENSE_LSB +: 2]   = sense_q;
      rdata_o[CTRL_THR_LSB +: THR_W] = thr_q;
      rdata_o[CTRL_IE_LSB +: NSRC]   = ie_q;
    end else begin
      rdata_o[STAT_COND_LSB +: NSRC] = cond;
      rdata_o[STAT_FLAG_LSB +: NSRC] = flag;
    end
  end

  assign thr_sel_o = thr_q;
  assign irq_o     = ~stop_i & |(flag & ie_q);
endmodule

// File: rtl/supply_mon_irq_chk.sv
module supply_mon_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       irq_o,
  input logic [1:0] sense_i,
  input logic [1:0] ie_i,
  input logic [1:0] cond_i,
  input logic [1:0] flag_i,
  input logic [1:0] clr_i
);
  AST_COND_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == 2'b00) |-> (cond_i == 2'b00)); // R5
  AST_LOW_SET_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i[0] != $past(cond_i[0])) |=> flag_i[0]); // R6
  AST_HIGH_SET_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i[1] != $past(cond_i[1])) |=> flag_i[1]); // R6
  AST_LOW_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_i[0] && cond_i[0] == $past(cond_i[0])) |=> !flag_i[0]); // R6
  AST_LOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[0] && !clr_i[0]) |=> flag_i[0]); // R8
  AST_HIGH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[1] && !clr_i[1]) |=> flag_i[1]); // R8
  AST_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && cond_i[0] == $past(cond_i[0])) |=> !flag_i[0]); // R8
  AST_IRQ_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !irq_o); // R10
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag_i[0] && ie_i[0]) || (flag_i[1] && ie_i[1]))); // R9
endmodule

bind supply_mon_irq supply_mon_irq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .stop_i (stop_i),
  .irq_o  (irq_o),
  .sense_i(sense_q),
  .ie_i   (ie_q),
  .cond_i (cond),
  .flag_i (flag),
  .clr_i  (clr)
);

// File: tb/supply_mon_irq_test.sv
`timescale 1ns/1ps
module supply_mon_irq_test;
  localparam int N = 4;

  logic       clk = 0, rst_n = 0, stop = 0, cmp_lo = 0, cmp_hi = 0, wr = 0;
  logic       addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0] thr;
  logic       irq;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  supply_mon_irq #(.FILT_N(N), .DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .cmp_low_i(cmp_lo),
    .cmp_high_i(cmp_hi), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .thr_sel_o(thr), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr_reg(logic a, logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(0, d); chk("R1 ctrl", d, 8'h00);
    rd_reg(1, d); chk("R1 stat", d, 8'h00);
    chk("R1 thr", {6'b0, thr}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr_reg(0, 8'h3C); rd_reg(0, d); chk("R2 ctrl readback", d, 8'h3C);
    chk("R3 thr code 3", {6'b0, thr}, 8'h03);
    wr_reg(0, 8'h04); chk("R3 thr code 1", {6'b0, thr}, 8'h01);
    wr_reg(0, 8'h08); chk("R3 thr code 2", {6'b0, thr}, 8'h02);
    wr_reg(0, 8'h00); chk("R3 thr code 0", {6'b0, thr}, 8'h00);
  endtask

  task automatic t_gating;
    logic [7:0] d;
    cmp_lo = 1; cmp_hi = 1; idle(20);
    rd_reg(1, d); chk("R5 gated with sense off", d, 8'h00);
    wr_reg(0, 8'h01); idle(2);
    rd_reg(1, d); chk("R5 R6 sense A rises conds", d, 8'h0F);
    wr_reg(1, 8'h0C);
    rd_reg(1, d); chk("R8 w1c both flags", d, 8'h03);
    wr_reg(0, 8'h02); idle(2);
    rd_reg(1, d); chk("R5 sense B alone", d, 8'h03);
  endtask

  task automatic t_filter;
    logic [7:0] d;
    cmp_lo = 0; idle(N - 1); cmp_lo = 1; idle(20);
    rd_reg(1, d); chk("R4 short glitch ignored", d, 8'h03);
    cmp_lo = 0; idle(N + 1);
    rd_reg(1, d); chk("R4 cond before window", {7'b0, d[0]}, 8'h01);
    idle(1);
    rd_reg(1, d); chk("R4 cond after window", {7'b0, d[0]}, 8'h00);
    idle(2);
    rd_reg(1, d); chk("R6 falling sets flag", d, 8'h06);
    wr_reg(1, 8'h00);
    rd_reg(1, d); chk("R8 write 0 no effect", d, 8'h06);
    wr_reg(1, 8'h04);
    rd_reg(1, d); chk("R8 clear low flag", d, 8'h02);
    cmp_lo = 1; idle(20);
    rd_reg(1, d); chk("R6 rising sets flag", d, 8'h07);
    wr_reg(1, 8'h04);
  endtask

  task automatic t_irq_stop;
    logic [7:0] d;
    cmp_hi = 0; idle(20);
    rd_reg(1, d); chk("R6 high falling", d, 8'h09);
    chk("R9 no enable no irq", {7'b0, irq}, 8'h00);
    wr_reg(0, 8'h12); #0.5;
    chk("R9 other source enable", {7'b0, irq}, 8'h00);
    wr_reg(0, 8'h22); #0.5;
    chk("R9 high enable irq", {7'b0, irq}, 8'h01);
    stop = 1; idle(3);
    chk("R10 stop masks irq", {7'b0, irq}, 8'h00);
    rd_reg(1, d); chk("R10 flags kept in stop", d, 8'h09);
    stop = 0; idle(3);
    chk("R10 irq back after stop", {7'b0, irq}, 8'h01);
    rd_reg(1, d); chk("R10 flags kept after stop", d, 8'h09);
    wr_reg(1, 8'h08);
    stop = 1; idle(3); stop = 0; idle(3);
    rd_reg(1, d); chk("R10 stop sets no flag", d, 8'h01);
    chk("R9 irq low after clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_disable_active;
    logic [7:0] d;
    wr_reg(0, 8'h32); idle(2);
    wr_reg(0, 8'h30); idle(2);
    rd_reg(1, d); chk("R7 disable while active", d, 8'h04);
    chk("R7 extra irq", {7'b0, irq}, 8'h01);
    wr_reg(1, 8'h04);
    rd_reg(1, d); chk("R8 cleared", d, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    wr_reg(0, 8'h31); idle(2);
    wr_reg(1, 8'h04);
    rd_reg(1, d); chk("R8 pre clear", d, 8'h01);
    wr_reg(0, 8'h30);
    wr_reg(1, 8'h04);
    rd_reg(1, d); chk("R8 set beats clear", d, 8'h04);
    wr_reg(1, 8'h04);
    rd_reg(1, d); chk("R8 later clear", d, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_gating;
    t_filter;
    t_irq_stop;
    t_disable_active;
    t_set_wins;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule